// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs single accesses on a synchronous external expansion bus with a 16-bit data path. Two memory spaces share the bus: a data space and a program space. The core raises a request strobe and gives a space select, an address, a read/write flag and write data. The block latches the request and drives the external address, data and strobes. It holds them for the number of wait clocks programmed for the addressed space, then returns a one-cycle done pulse, with read data for reads.

Each space has its own 5-bit wait-state field in a small configuration register. Each wait state adds exactly one clock to the access. The field for the addressed space is captured when the access starts. A later register write therefore changes only later accesses. While an access is running the block raises busy. A core that keeps its request raised is served as soon as the current access ends.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: After reset, busy and done are 0 and rd_n, wr_n, dsel_n and psel_n are all 1 (inactive). The configuration register reads back 10'h3FF, so both spaces start at 31 wait states.
- R2: The configuration register is loaded from cfg_wdata when cfg_we is 1 at a clock edge, and cfg_rdata returns it. Bits [4:0] hold the data-space wait count and bits [9:5] hold the program-space wait count.
- R3: An access to the data space (space = 0) with a programmed wait count N holds dsel_n low for exactly N+1 clocks. psel_n stays high during that access. N ranges over 0..31.
- R4: An access to the program space (space = 1) takes its length from bits [9:5]. It holds psel_n low for exactly that count plus one clocks, and dsel_n stays high.
- R5: With a wait count of 0, the strobes are active for a single clock.
- R6: The address, write data and strobes stay stable for every clock of an access. They equal the values presented with the accepted request.
- R7: For a read (wr = 0), rd_n is low during the access. xd_in is sampled on the last clock of the access. It appears on rdata together with a one-cycle done pulse in the following clock, and rdata keeps that value until the next read completes.
- R8: For a write (wr = 1), wr_n is low and xd_oe is 1 for the whole access, with xd_out equal to the write data. rd_n stays high. xd_oe is 0 whenever no write access is running.
- R9: busy is 1 for every clock of an access. A request raised while busy is not started. If it is held, it begins in the clock after the current access's done pulse.
- R10: The wait count is captured when an access is accepted. A configuration write during an access leaves that access's length unchanged and takes effect from the next access.
- R11: done is high for exactly one clock per access and never in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 10 | Configuration write value |
| cfg_rdata | output | 10 | Configuration register contents |
| req | input | 1 | Access request from the core |
| space | input | 1 | Space select: 0 data, 1 program |
| addr | input | 16 | Access address |
| wr | input | 1 | 1 write, 0 read |
| wdata | input | 16 | Write data |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read data |
| xa | output | 16 | External address bus |
| xd_out | output | 16 | External data bus, outgoing value |
| xd_oe | output | 1 | External data bus drive enable |
| xd_in | input | 16 | External data bus, incoming value |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dsel_n | output | 1 | Data-space select, active low |
| psel_n | output | 1 | Program-space select, active low |

## Verification
The hardest situation to reach is one where the outcome depends on when something happened inside an access, not on what was requested. Three cases fall under this: a read whose data sample must come from the last clock, a register write that lands mid-access, and a request held against busy. The bench's memory model drives valid read data only on the clock where the strobe has been low for the expected number of cycles and drives a marker value otherwise, so an early or late sample returns the wrong word. Separate tasks write the configuration register in the first clock of a running access and keep a second request raised with different address and space during a running access. They then check the first access's length and address, and the cycle in which the second one starts.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   localparam int NUM_SPACES = 2;

   typedef enum logic {
      SP_DATA = 1'b0,
      SP_PROG = 1'b1
   } space_e;

endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs
   import xbus_pkg::*;
#(
   parameter int WSW = 5,
   localparam int CW = WSW * NUM_SPACES,
   localparam int SELW = $clog2(NUM_SPACES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [CW-1:0]   wdata,
   output logic [CW-1:0]   rdata,
   input  logic [SELW-1:0] sel,
   output logic [WSW-1:0]  sel_waits
);

   logic [WSW-1:0] fld [NUM_SPACES];

   for (genvar g = 0; g < NUM_SPACES; g++) begin : g_fld
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fld[g] <= '1;
         else if (we)
            fld[g] <= wdata[g*WSW +: WSW];
      end
      assign rdata[g*WSW +: WSW] = fld[g];
   end

   assign sel_waits = fld[sel];

endmodule

// File: rtl/xbus_wait_cnt.sv
module xbus_wait_cnt #(
   parameter int WSW = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [WSW-1:0] ld_val,
   output logic           last
);

   logic [WSW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= ld_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
   import xbus_pkg::*;
#(
   parameter int DW  = 16,
   parameter int AW  = 16,
   parameter int WSW = 5,
   localparam int CW = WSW * NUM_SPACES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [CW-1:0] cfg_wdata,
   output logic [CW-1:0] cfg_rdata,
   input  logic          req,
   input  logic          space,
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] rdata,
   output logic [AW-1:0] xa,
   output logic [DW-1:0] xd_out,
   output logic          xd_oe,
   input  logic [DW-1:0] xd_in,
   output logic          rd_n,
   output logic          wr_n,
   output logic          dsel_n,
   output logic          psel_n
);

   if (DW < 1 || AW < 1) begin : g_bad_width
      $error("xbus_wait_ctrl: DW and AW must be positive");
   end
   if (WSW < 1 || WSW > 8) begin : g_bad_wsw
      $error("xbus_wait_ctrl: WSW must lie in 1..8");
   end

   logic           act_q;
   logic           wr_q;
   space_e         sp_q;
   logic [AW-1:0]  addr_q;
   logic [DW-1:0]  wdata_q;
   logic [DW-1:0]  rdata_q;
   logic           done_q;
   logic [WSW-1:0] sel_waits;
   logic           last;
   logic           start;
   logic           finish;

   assign start  = req && !act_q;
   assign finish = act_q && last;

   xbus_cfg_regs #(.WSW(WSW)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .wdata     (cfg_wdata),
      .rdata     (cfg_rdata),
      .sel       (space),
      .sel_waits (sel_waits)
   );

   xbus_wait_cnt #(.WSW(WSW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .ld_val (sel_waits),
      .last   (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         wr_q    <= 1'b0;
         sp_q    <= SP_DATA;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= finish;
         if (start) begin
            act_q   <= 1'b1;
            wr_q    <= wr;
            sp_q    <= space_e'(space);
            addr_q  <= addr;
            wdata_q <= wdata;
         end else if (finish) begin
            act_q <= 1'b0;
         end
         if (finish && !wr_q)
            rdata_q <= xd_in;
      end
   end

   assign busy   = act_q;
   assign done   = done_q;
   assign rdata  = rdata_q;
   assign xa     = addr_q;
   assign xd_out = wdata_q;
   assign xd_oe  = act_q && wr_q;
   assign rd_n   = !(act_q && !wr_q);
   assign wr_n   = !(act_q && wr_q);
   assign dsel_n = !(act_q && sp_q == SP_DATA);
   assign psel_n = !(act_q && sp_q == SP_PROG);

endmodule

// File: rtl/xbus_wait_ctrl_chk.sv
module xbus_wait_ctrl_chk #(
   parameter int DW  = 16,
   parameter int AW  = 16,
   parameter int WSW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic [AW-1:0] xa,
   input logic [DW-1:0] xd_out,
   input logic          xd_oe,
   input logic          rd_n,
   input logic          wr_n,
   input logic          dsel_n,
   input logic          psel_n
);

   logic [WSW+1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_cnt <= '0;
      else if (busy)
         run_cnt <= run_cnt + 1'b1;
      else
         run_cnt <= '0;
   end

   AST_RW_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R8
   AST_SEL_ONEHOT:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0({!dsel_n, !psel_n})); // R3
   AST_MAX_LEN:     assert property (@(posedge clk) disable iff (!rst_n) busy |-> (run_cnt < (2 ** WSW))); // R3
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
                       (busy && $past(busy)) |-> ($stable(xa) && $stable(xd_out) && $stable(rd_n) && $stable(dsel_n))); // R6
   AST_OE_WRITE:    assert property (@(posedge clk) disable iff (!rst_n) xd_oe |-> !wr_n); // R8
   AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
   AST_DONE_AFTER:  assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(busy)); // R7

endmodule

bind xbus_wait_ctrl xbus_wait_ctrl_chk #(.DW(DW), .AW(AW), .WSW(WSW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy   (busy),
   .done   (done),
   .xa     (xa),
   .xd_out (xd_out),
   .xd_oe  (xd_oe),
   .rd_n   (rd_n),
   .wr_n   (wr_n),
   .dsel_n (dsel_n),
   .psel_n (psel_n)
);

// File: tb/xbus_wait_ctrl_test.sv
`timescale 1ns/1ps
module xbus_wait_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [9:0]  cfg_wdata = '0;
   logic [9:0]  cfg_rdata;
   logic        req = 1'b0;
   logic        space = 1'b0;
   logic [15:0] addr = '0;
   logic        wr = 1'b0;
   logic [15:0] wdata = '0;
   logic        busy, done;
   logic [15:0] rdata, xa, xd_out, xd_in;
   logic        xd_oe, rd_n, wr_n, dsel_n, psel_n;

   int checks = 0;
   int fails = 0;
   int exp_n = 0;
   int rd_cnt = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   xbus_wait_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req(req), .space(space), .addr(addr), .wr(wr), .wdata(wdata),
      .busy(busy), .done(done), .rdata(rdata),
      .xa(xa), .xd_out(xd_out), .xd_oe(xd_oe), .xd_in(xd_in),
      .rd_n(rd_n), .wr_n(wr_n), .dsel_n(dsel_n), .psel_n(psel_n)
   );

   // slow memory: valid word only on the clock where the read has run exp_n+1 cycles
   always @(posedge clk) rd_cnt <= (!rd_n) ? rd_cnt + 1 : 0;
   assign xd_in = (!rd_n && rd_cnt == exp_n) ? (xa ^ 16'h5A5A) : 16'hBAD0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [9:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_acc(input bit sp, input bit w, input logic [15:0] a, input logic [15:0] d,
                         input int n, input bit mid, input logic [9:0] midv, input string tag);
      int len;
      bit ok;
      len = 0;
      ok = 1;
      exp_n = n;
      @(negedge clk);
      req = 1'b1; space = sp; addr = a; wr = w; wdata = d;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      while (!rd_n || !wr_n) begin
         len++;
         if (xa != a || xd_oe != w || (w && xd_out != d) || rd_n != w || wr_n != !w ||
             dsel_n != sp || psel_n != !sp || !busy || done)
            ok = 0;
         if (mid && len == 1) begin
            cfg_we = 1'b1; cfg_wdata = midv;
         end else begin
            cfg_we = 1'b0;
         end
         @(negedge clk);
         if (len > 40) break;
      end
      cfg_we = 1'b0;
      check(ok, {tag, " R6 R8 strobes/address/data stable"}, 0, 0);
      check(len == n + 1, {tag, " R3 R4 R5 access length"}, len, n + 1);
      check(done && !busy, {tag, " R7 done after last clock"}, done, 1);
      if (!w) check(rdata == (a ^ 16'h5A5A), {tag, " R7 read data"}, rdata, a ^ 16'h5A5A);
      @(negedge clk);
      check(!done, {tag, " R11 single done"}, done, 0);
      if (!w) check(rdata == (a ^ 16'h5A5A), {tag, " R7 rdata held"}, rdata, a ^ 16'h5A5A);
   endtask

   task automatic t_reset;
      check(!busy && !done && rd_n && wr_n && dsel_n && psel_n && !xd_oe,
            "R1 idle outputs after reset", {busy, done, rd_n, wr_n, dsel_n, psel_n}, 6'b001111);
      check(cfg_rdata == 10'h3FF, "R1 R2 config reset value", cfg_rdata, 10'h3FF);
   endtask

   task automatic t_cfg;
      write_cfg({5'd7, 5'd2});
      check(cfg_rdata == {5'd7, 5'd2}, "R2 config readback", cfg_rdata, {5'd7, 5'd2});
   endtask

   task automatic t_stall;
      int len;
      bit ok;
      write_cfg({5'd1, 5'd3});
      exp_n = 3;
      len = 0;
      ok = 1;
      @(negedge clk);
      req = 1'b1; space = 1'b0; addr = 16'h1234; wr = 1'b0;
      @(posedge clk);
      @(negedge clk);
      space = 1'b1; addr = 16'h4321;
      while (busy) begin
         len++;
         if (xa != 16'h1234 || dsel_n) ok = 0;
         @(negedge clk);
         if (len > 40) break;
      end
      check(ok, "R9 held request does not disturb running access", 0, 0);
      check(len == 4, "R9 first access length", len, 4);
      check(done && rdata == (16'h1234 ^ 16'h5A5A), "R9 R7 first access done", rdata, 16'h1234 ^ 16'h5A5A);
      exp_n = 1;
      @(negedge clk);
      req = 1'b0;
      check(busy && !psel_n && xa == 16'h4321, "R9 held request starts after done", xa, 16'h4321);
      @(negedge clk);
      @(negedge clk);
      check(done && rdata == (16'h4321 ^ 16'h5A5A), "R9 second access done", rdata, 16'h4321 ^ 16'h5A5A);
      @(negedge clk);
   endtask

   task automatic t_mid_cfg;
      write_cfg({5'd0, 5'd2});
      do_acc(1'b0, 1'b0, 16'h0F0F, 16'h0, 2, 1'b1, {5'd0, 5'd10}, "R10 access during write");
      check(cfg_rdata == {5'd0, 5'd10}, "R10 write landed", cfg_rdata, {5'd0, 5'd10});
      do_acc(1'b0, 1'b0, 16'h0E0E, 16'h0, 10, 1'b0, 10'h0, "R10 next access uses new count");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg();
      do_acc(1'b0, 1'b0, 16'hA001, 16'h0, 2, 1'b0, 10'h0, "R3 data read N=2");
      do_acc(1'b1, 1'b0, 16'hB002, 16'h0, 7, 1'b0, 10'h0, "R4 program read N=7");
      do_acc(1'b0, 1'b1, 16'hC003, 16'h1357, 2, 1'b0, 10'h0, "R8 data write N=2");
      write_cfg({5'd0, 5'd0});
      do_acc(1'b0, 1'b0, 16'hD004, 16'h0, 0, 1'b0, 10'h0, "R5 data read N=0");
      do_acc(1'b1, 1'b1, 16'hE005, 16'hFFFF, 0, 1'b0, 10'h0, "R5 program write N=0");
      write_cfg({5'd31, 5'd4});
      do_acc(1'b1, 1'b0, 16'hF006, 16'h0, 31, 1'b0, 10'h0, "R4 program read N=31");
      do_acc(1'b0, 1'b1, 16'h0007, 16'hA5A5, 4, 1'b0, 10'h0, "R8 data write N=4");
      check(!xd_oe && rd_n && wr_n, "R8 bus released when idle", xd_oe, 0);
      t_stall();
      t_mid_cfg();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule